// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable slave that answers a host exactly as a small 1024-bit serial EEPROM would. The host frames each instruction with a chip select and shifts bits in on a shift clock. The block decodes reads, single-location writes and erases, array-wide writes and erases, and the two instructions that turn programming on and off. Read data is shifted back out on a serial output that has a separate output-enable.

The storage is held in registers. A live organization input picks the word size: either sixty-four 16-bit words or one hundred twenty-eight bytes over the same bits. Every program or erase starts a self-timed cycle, modelled by a counter in system-clock cycles. If the host toggles chip select while that cycle runs, it can poll the busy or ready level on the output.

The shift clock, chip select and data input are resynchronised into the system clock domain. The system clock must run at least eight times faster than the shift clock.

Top module: `serial_eeprom_model`

## Requirements
- R1: A frame starts on the first 1 sampled on the data input after chip select rises. It is followed by a 2-bit opcode and an address, all MSB first. Opcode 10 reads, 01 writes and 11 erases one location. Opcode 00 uses the two top address bits as a sub-command: 11 enables programming, 00 disables it, 01 writes all words and 10 erases all words. The other address bits are don't-care but must still be clocked.
- R2: With the organization input high, the array is 64 words of 16 bits behind a 6-bit address. With it low, the array is 128 bytes behind a 7-bit address. Byte b shares storage with 16-bit word b>>1: an even b holds bits 15:8 and an odd b holds bits 7:0.
- R3: After the last address bit of a read, the output drives one 0 bit. It then drives the word MSB first, with each bit changing after a rising shift-clock edge.
- R4: After reset, programming is disabled, every storage bit is 1 and the output-enable is low.
- R5: While programming is disabled, write, erase, write-all and erase-all leave the array unchanged, and reads still work. Once enabled, programming stays enabled until a disable instruction.
- R6: A write stores its data word without a prior erase. An erase sets the addressed word to all ones. A write-all stores the data word in every location. An erase-all sets every bit to 1.
- R7: The program cycle starts after the final instruction bit and lasts PROG_CYCLES system clocks. No instruction is accepted while it runs.
- R8: If chip select goes low and then high while the cycle runs, the output is enabled and shows 0 while busy and 1 once done. If chip select rises only after the cycle ends, the output stays disabled.
- R9: The output-enable is low whenever chip select is low, within four system clocks.
- R10: Dropping chip select before a frame completes leaves the array and the enable state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select from the host |
| sk_i | input | 1 | Serial shift clock from the host |
| di_i | input | 1 | Serial data from the host |
| org16_i | input | 1 | High selects 16-bit words, low selects bytes |
| do_o | output | 1 | Serial data or status level |
| do_oe_o | output | 1 | Output-enable for do_o (low means high impedance) |

## Verification
The bench builds the block with PROG_CYCLES set to 300. That is shorter than one 25-bit write frame at sixteen system clocks per shift bit, yet long enough to lower and raise chip select while busy. This lets a single run observe the busy level, the ready level, a status request made too late, and a whole instruction sent into an active cycle and dropped. The word size is left at 16 bits, so both organizations and the byte-to-word overlap are reached by switching the organization input between frames.

// File: rtl/see_pkg.sv
package see_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_CMD, ST_DATA, ST_READ, ST_STAT, ST_DONE
    } see_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } see_op_e;

    typedef enum logic [1:0] {
        EX_LOCK   = 2'b00,
        EX_WRALL  = 2'b01,
        EX_ERALL  = 2'b10,
        EX_UNLOCK = 2'b11
    } see_ext_e;
endpackage

// File: rtl/see_sync.sv
module see_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/see_prog_timer.sv
module see_prog_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // a new program cycle is never launched on top of a running one
    p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
endmodule

// File: rtl/serial_eeprom_model.sv
module serial_eeprom_model
    import see_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int WORDS       = 64,
    parameter int PROG_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic org16_i,
    output logic do_o,
    output logic do_oe_o
);
    localparam int HALF_W = WORD_W / 2;
    localparam int AW_W   = $clog2(WORDS);
    localparam int AW_N   = AW_W + 1;
    localparam int SR_W   = AW_N + 2;
    localparam int CNT_W  = $clog2(WORD_W + SR_W + 1);

    typedef struct packed {
        see_state_e                   st;
        logic                         cs_prev;
        logic                         sk_prev;
        logic [CNT_W-1:0]             cnt;
        logic [SR_W-2:0]              sr;
        logic [AW_N-1:0]              addr;
        logic                         wall;
        logic [WORD_W-2:0]            dsr;
        logic [WORD_W-1:0]            osr;
        logic                         do_bit;
        logic                         en;
        logic [WORDS-1:0][WORD_W-1:0] mem;
    } regs_t;

    regs_t d, q;

    logic [2:0]        sync_v;
    logic              cs_s, sk_s, di_s, sk_rise, busy, prog_go;
    logic [CNT_W-1:0]  cmd_len, data_len, cnt_n;
    logic [SR_W-1:0]   sr_n;
    see_op_e           op;
    see_ext_e          ext;
    logic [AW_N-1:0]   addr_n, c_addr;
    logic [AW_W-1:0]   rd_widx, c_widx;
    logic [WORD_W-1:0] rd_word, c_val;
    logic              commit, c_all;

    see_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_i, sk_i, di_i}),
        .q_o   (sync_v)
    );
    assign cs_s = sync_v[2];
    assign sk_s = sync_v[1];
    assign di_s = sync_v[0];

    see_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_go),
        .busy_o  (busy)
    );

    always_comb begin
        d        = q;
        prog_go  = 1'b0;
        commit   = 1'b0;
        c_all    = 1'b0;
        c_addr   = '0;
        c_val    = '0;
        sk_rise  = sk_s & ~q.sk_prev;
        cmd_len  = org16_i ? CNT_W'(AW_W + 2) : CNT_W'(AW_N + 2);
        data_len = org16_i ? CNT_W'(WORD_W) : CNT_W'(HALF_W);
        cnt_n    = q.cnt + 1'b1;
        sr_n     = {q.sr, di_s};
        op       = see_op_e'(org16_i ? sr_n[AW_W+1:AW_W] : sr_n[AW_N+1:AW_N]);
        ext      = see_ext_e'(org16_i ? sr_n[AW_W-1:AW_W-2] : sr_n[AW_N-1:AW_N-2]);
        addr_n   = org16_i ? {1'b0, sr_n[AW_W-1:0]} : sr_n[AW_N-1:0];
        rd_widx  = org16_i ? addr_n[AW_W-1:0] : addr_n[AW_N-1:1];
        rd_word  = q.mem[rd_widx];
        d.cs_prev = cs_s;
        d.sk_prev = sk_s;

        if (!cs_s) begin
            d.st = ST_IDLE;
        end else if (!q.cs_prev) begin
            d.st = busy ? ST_STAT : ST_WAIT;
        end else if (sk_rise) begin
            case (q.st)
                ST_WAIT: if (di_s) begin
                    d.st  = ST_CMD;
                    d.cnt = '0;
                    d.sr  = '0;
                end
                ST_CMD: begin
                    d.sr  = sr_n[SR_W-2:0];
                    d.cnt = cnt_n;
                    if (cnt_n == cmd_len) begin
                        d.addr = addr_n;
                        d.cnt  = '0;
                        d.st   = ST_DONE;
                        case (op)
                            OP_READ: begin
                                d.st     = ST_READ;
                                d.do_bit = 1'b0;
                                d.osr    = org16_i ? rd_word :
                                           addr_n[0] ? {rd_word[HALF_W-1:0], HALF_W'(0)} :
                                                       {rd_word[WORD_W-1:HALF_W], HALF_W'(0)};
                            end
                            OP_WRITE: begin
                                d.st   = ST_DATA;
                                d.wall = 1'b0;
                                d.dsr  = '0;
                            end
                            OP_ERASE: begin
                                commit = q.en;
                                c_addr = addr_n;
                                c_val  = '1;
                            end
                            default: case (ext)
                                EX_UNLOCK: d.en = 1'b1;
                                EX_LOCK:   d.en = 1'b0;
                                EX_WRALL: begin
                                    d.st   = ST_DATA;
                                    d.wall = 1'b1;
                                    d.dsr  = '0;
                                end
                                default: begin
                                    commit = q.en;
                                    c_all  = 1'b1;
                                    c_val  = '1;
                                end
                            endcase
                        endcase
                    end
                end
                ST_DATA: begin
                    d.dsr = {q.dsr[WORD_W-3:0], di_s};
                    d.cnt = cnt_n;
                    if (cnt_n == data_len) begin
                        d.st   = ST_DONE;
                        commit = q.en;
                        c_all  = q.wall;
                        c_addr = q.addr;
                        c_val  = {q.dsr, di_s};
                    end
                end
                ST_READ: begin
                    d.do_bit = q.osr[WORD_W-1];
                    d.osr    = {q.osr[WORD_W-2:0], 1'b0};
                end
                default: ;
            endcase
        end

        c_widx = org16_i ? c_addr[AW_W-1:0] : c_addr[AW_N-1:1];
        if (commit) begin
            prog_go = 1'b1;
            for (int i = 0; i < WORDS; i++) begin
                if (c_all || AW_W'(i) == c_widx) begin
                    if (org16_i) begin
                        d.mem[i] = c_val;
                    end else begin
                        if (c_all || !c_addr[0]) d.mem[i][WORD_W-1:HALF_W] = c_val[HALF_W-1:0];
                        if (c_all ||  c_addr[0]) d.mem[i][HALF_W-1:0]      = c_val[HALF_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.mem <= '1;
        end else begin
            q <= d;
        end
    end

    assign do_oe_o = (q.st == ST_READ) || (q.st == ST_STAT);
    assign do_o    = (q.st == ST_STAT) ? ~busy : q.do_bit;

    // output released once chip select is seen low
    p_hiz_cs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !q.cs_prev |-> !do_oe_o);
    // no storage change while programming is locked
    p_locked_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !q.en |=> $stable(q.mem));
    // first driven read bit is the leading zero
    p_dummy_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == ST_READ) |-> !do_o);
    // no frame is decoded while the program cycle runs
    p_busy_no_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(q.st inside {ST_CMD, ST_DATA}));
endmodule

// File: tb/test_serial_eeprom_model.sv
module test_serial_eeprom_model;
    localparam int PROG = 300;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    wire  do_w, oe_w;
    int   checks = 0, fails = 0, low_cnt = 0;
    logic [15:0] ref_mem [64];
    bit   ref_en = 0;

    always #2 clk = ~clk;

    serial_eeprom_model #(.PROG_CYCLES(PROG)) i_serial_eeprom_model (
        .clk (clk), .rst_n (rst_n), .cs_i (cs), .sk_i (sk), .di_i (di),
        .org16_i (org), .do_o (do_w), .do_oe_o (oe_w)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // R9: per-clock reference for the output-enable
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs) low_cnt = 0; else low_cnt++;
            if (low_cnt >= 4) check("R9 output released", oe_w, 0);
        end
    end

    task automatic bit_cycle(input logic b, output logic s);
        di = b;
        repeat (HALF) @(negedge clk);
        s  = do_w;
        sk = 1'b1;
        repeat (HALF) @(negedge clk);
        sk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic s;
        for (int i = n - 1; i >= 0; i--) bit_cycle(v[i], s);
    endtask

    task automatic cs_up();
        cs = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_down();
        cs = 1'b0;
        di = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame(input logic [1:0] op, input logic [6:0] a, input logic [15:0] v, input bit data);
        cs_up();
        send(1, 1);
        send(op, 2);
        send(a, org ? 6 : 7);
        if (data) send(v, org ? 16 : 8);
    endtask

    task automatic prog(input logic [1:0] op, input logic [6:0] a, input logic [15:0] v, input bit data);
        frame(op, a, v, data);
        cs_down();
        repeat (PROG + 20) @(negedge clk);
    endtask

    // model of R2/R5/R6 storage update
    task automatic m_store(input logic [6:0] a, input logic [15:0] v, input bit all);
        if (ref_en) begin
            for (int i = 0; i < 64; i++) begin
                if (all || i == (org ? int'(a) : int'(a >> 1))) begin
                    if (org) ref_mem[i] = v;
                    else begin
                        if (all || !a[0]) ref_mem[i][15:8] = v[7:0];
                        if (all ||  a[0]) ref_mem[i][7:0]  = v[7:0];
                    end
                end
            end
        end
    endtask

    function automatic logic [15:0] m_get(input logic [6:0] a);
        if (org) return ref_mem[a[5:0]];
        return a[0] ? {8'h00, ref_mem[a >> 1][7:0]} : {8'h00, ref_mem[a >> 1][15:8]};
    endfunction

    task automatic check_read(input string req, input logic [6:0] a);
        logic s, dummy;
        logic [15:0] v = '0;
        frame(2'b10, a, 0, 0);
        bit_cycle(0, dummy);
        for (int i = 0; i < (org ? 16 : 8); i++) begin
            bit_cycle(0, s);
            v = {v[14:0], s};
        end
        cs_down();
        check({"R3 leading zero, ", req}, dummy, 0);
        check(req, v, m_get(a));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R4 output disabled after reset", oe_w, 0);
        check_read("R4 erased after reset", 5);

        // R5: locked write ignored
        prog(2'b01, 5, 16'h1234, 1); m_store(5, 16'h1234, 0);
        check_read("R5 write ignored while locked", 5);

        // R1: enable via extended opcode
        prog(2'b00, 7'b0110000, 0, 0); ref_en = 1;

        // R8: status polling during the program cycle
        frame(2'b01, 5, 16'hA5C3, 1);
        cs_down(); cs_up();
        check("R8 status enabled while busy", oe_w, 1);
        check("R8 busy level", do_w, 0);
        repeat (PROG) @(negedge clk);
        check("R8 ready level", do_w, 1);
        cs_down(); m_store(5, 16'hA5C3, 0);
        check_read("R6 write stored", 5);

        // R8: status asked too late
        frame(2'b01, 63, 16'h8001, 1);
        cs_down(); repeat (PROG + 20) @(negedge clk);
        cs_up();
        check("R8 no status after cycle end", oe_w, 0);
        cs_down(); m_store(63, 16'h8001, 0);
        check_read("R2 top word", 63);

        // R7: instruction sent during busy is dropped
        frame(2'b01, 20, 16'h1111, 1);
        cs_down(); m_store(20, 16'h1111, 0);
        frame(2'b01, 21, 16'h2222, 1);
        check("R7 status held through frame", oe_w, 1);
        check("R7 ready after cycle", do_w, 1);
        cs_down(); repeat (PROG + 20) @(negedge clk);
        check_read("R7 busy frame dropped", 21);
        check_read("R7 first write kept", 20);

        // R6: erase one word
        prog(2'b11, 5, 0, 0); m_store(5, 16'hFFFF, 0);
        check_read("R6 erase", 5);

        // R2: byte organization
        org = 1'b0;
        prog(2'b01, 7, 16'h003C, 1); m_store(7, 16'h003C, 0);
        check_read("R2 odd byte", 7);
        check_read("R2 even byte", 6);
        org = 1'b1;
        check_read("R2 word view of bytes", 3);

        // R6: write all
        prog(2'b00, 7'b0010000, 16'h0F0F, 1); m_store(0, 16'h0F0F, 1);
        check_read("R6 write-all low", 0);
        check_read("R6 write-all high", 40);

        // R10: aborted frame
        cs_up(); send(1, 1); send(2'b01, 2); send(9, 6); send(4'hD, 4);
        cs_down(); repeat (PROG + 20) @(negedge clk);
        check_read("R10 aborted write", 9);

        // R6: erase all
        prog(2'b00, 7'b0100000, 0, 0); m_store(0, 16'hFFFF, 1);
        check_read("R6 erase-all", 12);

        // R5: locked programming ignored
        prog(2'b01, 2, 16'h0000, 1); m_store(2, 16'h0000, 0);
        prog(2'b00, 7'b0000000, 0, 0); ref_en = 0;
        prog(2'b00, 7'b0100000, 0, 0); m_store(0, 16'hFFFF, 1);
        prog(2'b11, 2, 0, 0); m_store(2, 16'hFFFF, 0);
        prog(2'b00, 7'b0010000, 16'h5555, 1); m_store(0, 16'h5555, 1);
        check_read("R5 locked erase ignored", 2);
        check_read("R5 locked write-all ignored", 12);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule